// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps the books for a shared packet buffer cut into 256-byte pages. It does not hold packet data. It hands out packet numbers, records which pages each packet owns, keeps a transmit queue and a receive FIFO of packet numbers, and returns pages to the free pool when packets are released. The buffer size is a whole number of 2 KiB units, and the default of four units gives 32 pages. The number of packet numbers equals the number of pages, so a free packet number always exists whenever a page is free.

A host drives a command port with five operations: allocate, reset, release the receive head, free the selected packet, and enqueue the selected packet. Each accepted command raises a busy flag for a fixed two cycles. An allocation result holds a packet number and a failure flag. Two interrupt bits report a finished allocation and a drained transmit queue, and both are cleared by writing ones. A receive-side agent pushes finished packet numbers into the receive FIFO. A transmit-side agent pops the queue head, takes it into flight, and reports completion. In auto-release mode, completion frees the packet's pages.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset, busy, tx_avail, alloc_fail and both interrupt bits are 0, rx_empty is 1, and every page is free (four 7-page allocations succeed and a fifth fails).
- R2: Command codes on cmd_op are 1 allocate, 2 reset, 3 release, 4 free-packet and 5 enqueue. A command presented while busy is 0 is accepted at that clock edge. Busy is then 1 for exactly two cycles. A command presented while busy is 1 is ignored.
- R3: An allocate with page field n (cmd_arg) needs n+1 pages. On success, alloc_fail reads 0, alloc_pkt reads the lowest packet number not in use, and irq_alloc_done is set.
- R4: An allocate fails if n exceeds 6 or if fewer than n+1 pages are free. On failure alloc_fail reads 1, no pages are taken, and irq_alloc_done is not set.
- R5: Free-packet (code 4) returns all pages and the packet number of the packet on cmd_sel. It has no effect on a packet that is not allocated.
- R6: Enqueue (code 5) appends cmd_sel to the transmit queue only if that packet is allocated. tx_head_pkt presents queued packets in first-in-first-out order while tx_avail is 1.
- R7: tx_pop moves the queue head into flight when nothing is in flight. When tx_done arrives with auto_release at 1, the in-flight packet is freed. With auto_release at 0, the packet stays allocated.
- R8: irq_tx_empty is set when a transmission completes with the transmit queue empty. Writing irq_clr_mask bit 1 with irq_clr_we clears it. Writing bit 0 only leaves it set.
- R9: rx_push_valid appends rx_push_pkt to the receive FIFO, and rx_head_pkt and rx_empty report its head. Release (code 3) pops the head and frees that packet. Release on an empty FIFO has no effect.
- R10: Reset (code 2) frees every page and packet number and empties both the transmit queue and the receive FIFO.
- R11: Writing irq_clr_mask bit 0 with irq_clr_we clears irq_alloc_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | ARG_W | Page field for allocate |
| cmd_sel | input | PKT_W | Selected packet number for free-packet and enqueue |
| busy | output | 1 | Command in progress |
| alloc_fail | output | 1 | Last allocation failed |
| alloc_pkt | output | PKT_W | Packet number from the last successful allocation |
| irq_alloc_done | output | 1 | Allocation-done interrupt |
| irq_tx_empty | output | 1 | Transmit-drained interrupt |
| irq_clr_we | input | 1 | Interrupt clear strobe |
| irq_clr_mask | input | 2 | Write-one-to-clear mask (bit 0 alloc-done, bit 1 tx-empty) |
| rx_push_valid | input | 1 | Receive agent push |
| rx_push_pkt | input | PKT_W | Packet number pushed |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_head_pkt | output | PKT_W | Receive FIFO head |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_head_pkt | output | PKT_W | Transmit queue head |
| tx_pop | input | 1 | Take queue head into flight |
| tx_done | input | 1 | In-flight transmission finished |
| auto_release | input | 1 | Free packets on completion |

## Verification
The bench sweeps every page field, including the out-of-range value 7, against a freshly cleared pool and against a full one. A design that sized requests as n pages instead of n+1, or that accepted n=7, would return a wrong fail flag. It then holds a command valid through the busy window. An allocator that accepted the extra strobe would hand out one packet number too many, and that shows up in the next packet number returned. Frees arrive by three routes: a host command, a receive release, and auto-release on completion. In each case the bench checks that the lowest packet number returned by the next allocation comes back. A design that leaked pages, or freed the packet in flight when auto-release was off, would return the wrong number. Enqueueing an unallocated packet and releasing from an empty FIFO are both checked for having no effect.

// File: rtl/pba_pkg.sv
// Shared command codes for the packet buffer page allocator.
package pba_pkg;
    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ALLOC   = 3'd1,
        OP_RESET   = 3'd2,
        OP_RELEASE = 3'd3,
        OP_FREE    = 3'd4,
        OP_ENQUEUE = 3'd5
    } cmd_op_e;
endpackage

// File: rtl/pba_cmd_ctrl.sv
// Command acceptance and busy timing.
// Accepts a command only when idle, then holds busy for BUSY_CYCLES cycles.
// Assumes cmd_valid is a level sampled at each clock edge.
module pba_cmd_ctrl #(
    parameter int BUSY_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    output logic accept,
    output logic busy
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    logic [BW-1:0] left_q;

    assign busy   = (left_q != '0);
    assign accept = cmd_valid && !busy;

    // Load the busy window on accept, count it down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (accept)
            left_q <= BW'(BUSY_CYCLES);
        else if (busy)
            left_q <= left_q - BW'(1);
    end
endmodule

// File: rtl/pba_lowest.sv
// Priority finder: index of the lowest set bit of a vector.
// Assumes N is at most 2**IW.
module pba_lowest #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    // Scan downward so the lowest set bit is the last one written.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pba_page_pick.sv
// Page selector: marks the `need` lowest free pages and reports whether
// enough free pages exist. The selection is meaningful only when enough=1.
module pba_page_pick #(
    parameter int NP = 32,
    parameter int CW = 6
) (
    input  logic [NP-1:0] free_map,
    input  logic [CW-1:0] need,
    output logic [NP-1:0] pick,
    output logic          enough
);
    logic [CW-1:0] taken;
    logic [CW-1:0] total;

    // Walk pages from the lowest upward, taking free ones until need is met.
    always_comb begin
        pick  = '0;
        taken = '0;
        total = '0;
        for (int i = 0; i < NP; i++) begin
            total = total + CW'(free_map[i]);
            if (free_map[i] && (taken < need)) begin
                pick[i] = 1'b1;
                taken   = taken + CW'(1);
            end
        end
        enough = (total >= need);
    end
endmodule

// File: rtl/pba_fifo.sv
// Small synchronous FIFO of packet numbers with a synchronous clear.
// A push when full and a pop when empty are dropped. The head is shown
// without a read strobe.
module pba_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_q];

    // Store pushed entries.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_q] <= push_data;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push)
                wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
            if (do_pop)
                rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
            if (do_push && !do_pop)
                cnt_q <= cnt_q + CW'(1);
            else if (do_pop && !do_push)
                cnt_q <= cnt_q - CW'(1);
        end
    end
endmodule

// File: rtl/pkt_page_alloc.sv
// Packet buffer page allocator top.
// Tracks free 256-byte pages in a bitmap and the page set of each packet
// number. It also holds the transmit queue, the packet in flight and the
// receive FIFO. Commands take effect at their accept edge.
// Assumes MEM_2K_UNITS*8 is a power of two.
module pkt_page_alloc
    import pba_pkg::*;
#(
    parameter int MEM_2K_UNITS = 4,
    parameter int MAX_FIELD    = 6,
    parameter int ARG_W        = 3,
    parameter int BUSY_CYCLES  = 2,
    parameter int PKT_W        = $clog2(MEM_2K_UNITS * 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [ARG_W-1:0] cmd_arg,
    input  logic [PKT_W-1:0] cmd_sel,
    output logic             busy,
    output logic             alloc_fail,
    output logic [PKT_W-1:0] alloc_pkt,
    output logic             irq_alloc_done,
    output logic             irq_tx_empty,
    input  logic             irq_clr_we,
    input  logic [1:0]       irq_clr_mask,
    input  logic             rx_push_valid,
    input  logic [PKT_W-1:0] rx_push_pkt,
    output logic             rx_empty,
    output logic [PKT_W-1:0] rx_head_pkt,
    output logic             tx_avail,
    output logic [PKT_W-1:0] tx_head_pkt,
    input  logic             tx_pop,
    input  logic             tx_done,
    input  logic             auto_release
);
    localparam int NP   = MEM_2K_UNITS * 8;
    localparam int CW   = $clog2(NP + 1);
    localparam logic [ARG_W-1:0] MAXF = ARG_W'(MAX_FIELD);

    cmd_op_e op;
    logic accept;
    logic is_alloc, reset_go, release_go, free_go, enq_go;
    logic pop_go, done_go, ar_go, alloc_ok;

    logic [NP-1:0] free_map_q;
    logic [NP-1:0] slot_used;
    logic [NP-1:0] own_mask [NP];
    logic [NP-1:0] pick;
    logic [NP-1:0] rel_vec;
    logic [NP-1:0] freed_pages;
    logic [CW-1:0] need;
    logic          enough, slot_found;
    logic [PKT_W-1:0] slot_idx;

    logic rxq_full, txq_empty, txq_full;
    logic fly_vld_q;
    logic [PKT_W-1:0] fly_pkt_q;

    assign op = cmd_op_e'(cmd_op);

    pba_cmd_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .accept(accept), .busy(busy)
    );

    assign need = CW'(cmd_arg) + CW'(1);

    pba_page_pick #(.NP(NP), .CW(CW)) pick_i (
        .free_map(free_map_q), .need(need), .pick(pick), .enough(enough)
    );

    pba_lowest #(.N(NP), .IW(PKT_W)) slot_i (
        .vec(~slot_used), .idx(slot_idx), .found(slot_found)
    );

    // Decode the accepted command and the agent events into actions.
    always_comb begin
        is_alloc   = accept && (op == OP_ALLOC);
        reset_go   = accept && (op == OP_RESET);
        release_go = accept && (op == OP_RELEASE) && !rx_empty;
        free_go    = accept && (op == OP_FREE) && slot_used[cmd_sel];
        enq_go     = accept && (op == OP_ENQUEUE) && slot_used[cmd_sel] && !txq_full;
        alloc_ok   = is_alloc && (cmd_arg <= MAXF) && enough && slot_found;
        pop_go     = tx_pop && !txq_empty && !fly_vld_q;
        done_go    = tx_done && fly_vld_q;
        ar_go      = done_go && auto_release;
    end

    // Gather the packet numbers released this cycle, from any route.
    always_comb begin
        rel_vec = '0;
        if (release_go) rel_vec = rel_vec | (NP'(1) << rx_head_pkt);
        if (free_go)    rel_vec = rel_vec | (NP'(1) << cmd_sel);
        if (ar_go)      rel_vec = rel_vec | (NP'(1) << fly_pkt_q);
    end

    // Union of the pages owned by the released packets.
    always_comb begin
        freed_pages = '0;
        for (int p = 0; p < NP; p++)
            if (rel_vec[p]) freed_pages = freed_pages | own_mask[p];
    end

    // Per-packet ownership records.
    for (genvar g = 0; g < NP; g++) begin : g_slot
        // Claim on allocation, drop on release or reset.
        always_ff @(posedge clk) begin
            if (!rst_n || reset_go) begin
                slot_used[g] <= 1'b0;
                own_mask[g]  <= '0;
            end else if (alloc_ok && (slot_idx == PKT_W'(g))) begin
                slot_used[g] <= 1'b1;
                own_mask[g]  <= pick;
            end else if (rel_vec[g]) begin
                slot_used[g] <= 1'b0;
                own_mask[g]  <= '0;
            end
        end
    end

    // Free page bitmap: take picked pages, return freed ones.
    always_ff @(posedge clk) begin
        if (!rst_n || reset_go)
            free_map_q <= '1;
        else
            free_map_q <= (free_map_q & ~(alloc_ok ? pick : '0)) | freed_pages;
    end

    // Allocation result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_fail <= 1'b0;
            alloc_pkt  <= '0;
        end else if (is_alloc) begin
            alloc_fail <= !alloc_ok;
            if (alloc_ok) alloc_pkt <= slot_idx;
        end
    end

    // Interrupt bits: set by events, cleared by writing ones; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_alloc_done <= 1'b0;
            irq_tx_empty   <= 1'b0;
        end else begin
            if (alloc_ok)
                irq_alloc_done <= 1'b1;
            else if (irq_clr_we && irq_clr_mask[0])
                irq_alloc_done <= 1'b0;
            if (done_go && txq_empty && !enq_go)
                irq_tx_empty <= 1'b1;
            else if (irq_clr_we && irq_clr_mask[1])
                irq_tx_empty <= 1'b0;
        end
    end

    // The packet currently being transmitted.
    always_ff @(posedge clk) begin
        if (!rst_n || reset_go) begin
            fly_vld_q <= 1'b0;
            fly_pkt_q <= '0;
        end else if (pop_go) begin
            fly_vld_q <= 1'b1;
            fly_pkt_q <= tx_head_pkt;
        end else if (done_go) begin
            fly_vld_q <= 1'b0;
        end
    end

    pba_fifo #(.DEPTH(NP), .W(PKT_W)) txq_i (
        .clk(clk), .rst_n(rst_n), .clear(reset_go),
        .push(enq_go), .push_data(cmd_sel), .pop(pop_go),
        .head(tx_head_pkt), .empty(txq_empty), .full(txq_full)
    );

    pba_fifo #(.DEPTH(NP), .W(PKT_W)) rxq_i (
        .clk(clk), .rst_n(rst_n), .clear(reset_go),
        .push(rx_push_valid), .push_data(rx_push_pkt), .pop(release_go),
        .head(rx_head_pkt), .empty(rx_empty), .full(rxq_full)
    );

    assign tx_avail = !txq_empty;

    // The receive FIFO depth equals the packet count, so it cannot fill
    // with distinct packets; overflow pushes are dropped inside the FIFO.
    logic unused_rx_full;
    assign unused_rx_full = rxq_full;
endmodule

// File: rtl/pkt_page_alloc_chk.sv
// Checker for pkt_page_alloc, attached with bind. Watches ports only.
module pkt_page_alloc_chk #(
    parameter int MAX_FIELD = 6,
    parameter int ARG_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [ARG_W-1:0] cmd_arg,
    input logic             busy,
    input logic             alloc_fail,
    input logic             rx_push_valid,
    input logic             rx_empty,
    input logic             tx_avail,
    input logic             tx_done,
    input logic             irq_clr_we,
    input logic [1:0]       irq_clr_mask,
    input logic             irq_tx_empty
);
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy);

    p_oversize_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 3'd1 && cmd_arg > ARG_W'(MAX_FIELD)) |=> alloc_fail);

    p_rx_stay_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && !rx_push_valid) |=> rx_empty);

    p_txe_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_we && irq_clr_mask[1] && !tx_done) |=> !irq_tx_empty);

    p_reset_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 3'd2) |=> (rx_empty && !tx_avail));
endmodule

bind pkt_page_alloc pkt_page_alloc_chk #(.MAX_FIELD(MAX_FIELD), .ARG_W(ARG_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .busy(busy), .alloc_fail(alloc_fail),
    .rx_push_valid(rx_push_valid), .rx_empty(rx_empty), .tx_avail(tx_avail),
    .tx_done(tx_done), .irq_clr_we(irq_clr_we), .irq_clr_mask(irq_clr_mask),
    .irq_tx_empty(irq_tx_empty)
);

// File: tb/pkt_page_alloc_tb_top.sv
`timescale 1ns/1ps
module pkt_page_alloc_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [2:0] cmd_arg = 3'd0;
    logic [4:0] cmd_sel = 5'd0;
    logic busy, alloc_fail, irq_alloc_done, irq_tx_empty;
    logic [4:0] alloc_pkt, rx_head_pkt, tx_head_pkt;
    logic irq_clr_we = 1'b0;
    logic [1:0] irq_clr_mask = 2'b00;
    logic rx_push_valid = 1'b0;
    logic [4:0] rx_push_pkt = 5'd0;
    logic rx_empty, tx_avail;
    logic tx_pop = 1'b0, tx_done = 1'b0, auto_release = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    bit m_used [32];
    int m_pg   [32];
    int m_free;

    always #4 clk = ~clk;

    pkt_page_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .cmd_sel(cmd_sel), .busy(busy),
        .alloc_fail(alloc_fail), .alloc_pkt(alloc_pkt),
        .irq_alloc_done(irq_alloc_done), .irq_tx_empty(irq_tx_empty),
        .irq_clr_we(irq_clr_we), .irq_clr_mask(irq_clr_mask),
        .rx_push_valid(rx_push_valid), .rx_push_pkt(rx_push_pkt),
        .rx_empty(rx_empty), .rx_head_pkt(rx_head_pkt),
        .tx_avail(tx_avail), .tx_head_pkt(tx_head_pkt),
        .tx_pop(tx_pop), .tx_done(tx_done), .auto_release(auto_release)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic m_reset();
        for (int i = 0; i < 32; i++) begin
            m_used[i] = 0;
            m_pg[i] = 0;
        end
        m_free = 32;
    endtask

    task automatic m_rel(input int p);
        if (m_used[p]) begin
            m_free += m_pg[p];
            m_used[p] = 0;
        end
    endtask

    // Issue one command and check the busy window (R2).
    task automatic issue(input int op, input int arg, input int sel);
        cmd_op = 3'(op); cmd_arg = 3'(arg); cmd_sel = 5'(sel); cmd_valid = 1'b1;
        tick();
        cmd_valid = 1'b0;
        chk("R2 busy cycle 1", busy, 1);
        tick();
        chk("R2 busy cycle 2", busy, 1);
        tick();
        chk("R2 busy released", busy, 0);
    endtask

    task automatic reset_cmd();
        issue(2, 0, 0);
        m_reset();
    endtask

    task automatic alloc_check(input int arg, input string tag);
        int need = arg + 1;
        bit fail;
        int pkt = 0;
        fail = (arg > 6) || (m_free < need);
        if (!fail) begin
            for (int p = 31; p >= 0; p--) if (!m_used[p]) pkt = p;
            m_used[pkt] = 1; m_pg[pkt] = need; m_free -= need;
        end
        issue(1, arg, 0);
        chk({tag, " R4 fail flag"}, alloc_fail, int'(fail));
        if (!fail) begin
            chk({tag, " R3 packet number"}, alloc_pkt, pkt);
            chk({tag, " R3 alloc irq"}, irq_alloc_done, 1);
            irq_clr_we = 1'b1; irq_clr_mask = 2'b01;
            tick();
            irq_clr_we = 1'b0; irq_clr_mask = 2'b00;
            chk("R11 alloc irq cleared", irq_alloc_done, 0);
        end else begin
            chk({tag, " R4 no irq on fail"}, irq_alloc_done, 0);
        end
    endtask

    task automatic free_cmd(input int sel);
        issue(4, 0, sel);
        m_rel(sel);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 tx_avail", tx_avail, 0);
        chk("R1 irq alloc", irq_alloc_done, 0);
        chk("R1 irq txe", irq_tx_empty, 0);
        chk("R1 alloc_fail", alloc_fail, 0);
        for (int k = 0; k < 5; k++) alloc_check(6, "R1 full pool");

        // Sweep every page field on an empty pool (R3, R4)
        for (int a = 0; a < 8; a++) begin
            reset_cmd();
            alloc_check(a, "sweep empty");
        end

        // Fill the pool, then sweep every field against what is left
        reset_cmd();
        for (int k = 0; k < 6; k++) alloc_check(6, "fill");
        alloc_check(3, "fill tail");
        for (int a = 0; a < 8; a++) alloc_check(a, "sweep full");
        // R5: freeing packet 1 returns its pages and number
        free_cmd(1);
        alloc_check(6, "R5 reuse");
        free_cmd(9);
        alloc_check(0, "R5 unallocated free");

        // Mixed allocate/free pattern against the model
        reset_cmd();
        for (int i = 0; i < 24; i++) begin
            alloc_check((i * 3) % 8, "mixed");
            if (i % 3 == 2) free_cmd(i % 5);
        end

        // R2: strobe held through busy is ignored
        reset_cmd();
        cmd_op = 3'd1; cmd_arg = 3'd0; cmd_valid = 1'b1;
        tick(); tick(); tick();
        cmd_valid = 1'b0;
        m_used[0] = 1; m_pg[0] = 1; m_free -= 1;
        chk("R2 held strobe pkt", alloc_pkt, 0);
        irq_clr_we = 1'b1; irq_clr_mask = 2'b01; tick();
        irq_clr_we = 1'b0; irq_clr_mask = 2'b00;
        alloc_check(0, "R2 after held strobe");

        // Transmit path (R6, R7, R8)
        reset_cmd();
        alloc_check(0, "tx setup");
        alloc_check(1, "tx setup");
        issue(5, 0, 5);
        chk("R6 unallocated enqueue ignored", tx_avail, 0);
        issue(5, 0, 1);
        issue(5, 0, 0);
        chk("R6 tx_avail", tx_avail, 1);
        chk("R6 head first", tx_head_pkt, 1);
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        chk("R8 done without flight ignored", irq_tx_empty, 0);
        tx_pop = 1'b1; tick(); tx_pop = 1'b0;
        chk("R6 head second", tx_head_pkt, 0);
        auto_release = 1'b1; tx_done = 1'b1; tick(); tx_done = 1'b0;
        m_rel(1);
        chk("R8 no irq while queue holds", irq_tx_empty, 0);
        tx_pop = 1'b1; tick(); tx_pop = 1'b0;
        chk("R6 queue drained", tx_avail, 0);
        auto_release = 1'b0; tx_done = 1'b1; tick(); tx_done = 1'b0;
        chk("R8 tx empty irq", irq_tx_empty, 1);
        alloc_check(0, "R7 auto freed pkt 1");
        alloc_check(0, "R7 pkt 0 kept");
        irq_clr_we = 1'b1; irq_clr_mask = 2'b01; tick();
        chk("R8 other bit no effect", irq_tx_empty, 1);
        irq_clr_mask = 2'b10; tick();
        irq_clr_we = 1'b0; irq_clr_mask = 2'b00;
        chk("R8 w1c clears", irq_tx_empty, 0);

        // Receive path (R9)
        reset_cmd();
        alloc_check(0, "rx setup");
        alloc_check(0, "rx setup");
        alloc_check(0, "rx setup");
        rx_push_valid = 1'b1; rx_push_pkt = 5'd2; tick();
        rx_push_pkt = 5'd0; tick();
        rx_push_valid = 1'b0;
        chk("R9 not empty", rx_empty, 0);
        chk("R9 head", rx_head_pkt, 2);
        issue(3, 0, 0); m_rel(2);
        chk("R9 next head", rx_head_pkt, 0);
        issue(3, 0, 0); m_rel(0);
        chk("R9 empty after releases", rx_empty, 1);
        issue(3, 0, 0);
        chk("R9 release on empty", rx_empty, 1);
        alloc_check(0, "R9 freed pkt 0");
        alloc_check(0, "R9 freed pkt 2");
        alloc_check(0, "R9 nothing extra freed");

        // Reset command (R10)
        issue(5, 0, 1);
        rx_push_valid = 1'b1; rx_push_pkt = 5'd1; tick(); rx_push_valid = 1'b0;
        reset_cmd();
        chk("R10 tx queue empty", tx_avail, 0);
        chk("R10 rx fifo empty", rx_empty, 1);
        for (int k = 0; k < 5; k++) alloc_check(6, "R10 full pool");

        done_flag = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule